// File: doc/BRIEF.md
# Serial Gain Word Programmer

This block sits on the host side of a three-wire gain port on a variable-gain line driver. A local agent hands it an 8-bit gain code over a valid/ready handshake. The block then plays out one write frame on the port. It first drops an active-low frame enable, then sends exactly eight serial clock pulses carrying the code most significant bit first, and then raises the enable again so that the receiver commits the word. The serial clock stays low outside that burst, which keeps clock feedthrough off the analog output for as long as no word is being written.

Every interval in the frame is a parameter counted in system clock cycles. These intervals are the enable-to-first-pulse lead, the pulse high and low times, the enable hold after the last pulse, and the settle wait after commit. The defaults are sized for a 125 MHz system clock. After the settle wait the block pulses `done` and frees the handshake. A separate one-bit amplifier-enable register is written through its own strobe. A write that lands during a frame is parked and takes effect only once that frame has finished.

Top module: `gain_serial_master`

## Requirements
- R1: While reset is asserted and right after it, `ser_en_n` is 1, `ser_clk` is 0, `ser_dat` is 0, `busy` is 0, `req_ready` is 1, `done` is 0 and `amp_en` equals `AMP_EN_RST` (default 0).
- R2: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `busy` is 1 and `ser_en_n` is 0.
- R3: Every frame carries exactly `CODE_W` (8) rising edges of `ser_clk`. `ser_clk` is 0 in every cycle where `ser_en_n` is 1.
- R4: The value on `ser_dat` at the k-th rising edge of `ser_clk` in a frame is bit `CODE_W-k` of the accepted code, so bit 7 goes first and bit 0 goes last.
- R5: In system cycles, `ser_en_n` low to the first `ser_clk` rise takes `EN_SETUP_CYC` (3). Each high phase lasts `CLK_HIGH_CYC` (2). Each low phase between pulses lasts `CLK_LOW_CYC` (2). The last falling edge of `ser_clk` to the rise of `ser_en_n` takes `EN_HOLD_CYC` (1).
- R6: `ser_dat` only changes when `ser_clk` falls or when a frame starts. It never changes while `ser_clk` stays high.
- R7: `done` is a one-cycle pulse that appears exactly `SETTLE_CYC` (4) cycles after `ser_en_n` rises. In that same cycle `busy` is already 0, and `done` never appears at any other time.
- R8: `req_ready` is the inverse of `busy`. A request raised during a frame is not taken until that frame's `done` cycle, and its word follows in the next frame.
- R9: An `amp_wr` strobe in a cycle where `busy` is 0 sets `amp_en` to `amp_wdata` from the next cycle. During a frame, `amp_en` stays unchanged, the last value written is kept, and it shows on `amp_en` in the cycle after `done`.
- R10: At period `SYS_PERIOD_PS` (8000 ps), the cycle counts meet these minimums: clock high 12 ns, clock period 32 ns, data setup 6.5 ns, data hold 5 ns, enable setup 17 ns, enable hold 3 ns, and commit settle 30 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Gain code request |
| req_code | input | CODE_W | Gain code to program |
| req_ready | output | 1 | Request can be taken |
| amp_wr | input | 1 | Amplifier-enable register write strobe |
| amp_wdata | input | 1 | Amplifier-enable value to write |
| amp_en | output | 1 | Amplifier enable to the line driver (1 = on) |
| ser_en_n | output | 1 | Active-low frame enable; its rising edge commits the word |
| ser_clk | output | 1 | Burst serial clock |
| ser_dat | output | 1 | Serial data, MSB first |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse once the committed gain has settled |

## Verification
Any wrong state in the sequencer or phase timer shows up on the pins within the same frame. It appears as a phase length that differs from its parameter by a cycle, a missing or extra pulse, or a `done` that comes early or late against the enable rise. A fault in the shift register or bit counter shows up when the frame closes. At that point the word rebuilt from the rising edges no longer matches the code that was accepted, or the pulse count is not eight. A fault in the parked amplifier write shows up in the cycle after `done`, or as a change of `amp_en` during a frame.

// File: rtl/gsm_pkg.sv
package gsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_HIGH   = 3'd2,
    ST_LOW    = 3'd3,
    ST_HOLD   = 3'd4,
    ST_SETTLE = 3'd5
  } gsm_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gsm_timer.sv
module gsm_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;
  logic          dec_en;

  assign dec_en = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec_en) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = ~dec_en;
endmodule

// File: rtl/gsm_shift.sv
module gsm_shift #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] load_code,
  input  logic              shift,
  output logic              dout,
  output logic              last_bit
);
  localparam int BW = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(CODE_W - 1);

  logic [CODE_W-1:0] sh_q;
  logic [BW-1:0]     idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_code;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {sh_q[CODE_W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign dout     = sh_q[CODE_W-1];
  assign last_bit = (idx_q == LAST_IDX);
endmodule

// File: rtl/gsm_seq.sv
module gsm_seq
  import gsm_pkg::*;
#(
  parameter int TW           = 4,
  parameter int EN_SETUP_CYC = 3,
  parameter int CLK_HIGH_CYC = 2,
  parameter int CLK_LOW_CYC  = 2,
  parameter int EN_HOLD_CYC  = 1,
  parameter int SETTLE_CYC   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          t_zero,
  input  logic          last_bit,
  output logic          t_load,
  output logic [TW-1:0] t_val,
  output logic          sh_load,
  output logic          sh_shift,
  output logic          en_n,
  output logic          sclk,
  output logic          done,
  output logic          busy
);
  localparam logic [TW-1:0] LD_SETUP  = TW'(EN_SETUP_CYC - 1);
  localparam logic [TW-1:0] LD_HIGH   = TW'(CLK_HIGH_CYC - 1);
  localparam logic [TW-1:0] LD_LOW    = TW'(CLK_LOW_CYC - 1);
  localparam logic [TW-1:0] LD_HOLD   = TW'(EN_HOLD_CYC - 1);
  localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_CYC - 1);

  gsm_state_e st_q, st_d;
  logic       en_n_q, sclk_q, done_q;
  logic       en_n_d, sclk_d, done_d;

  always_comb begin
    st_d     = st_q;
    t_load   = 1'b0;
    t_val    = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    done_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fire) begin
          st_d    = ST_SETUP;
          t_load  = 1'b1;
          t_val   = LD_SETUP;
          sh_load = 1'b1;
        end
      end
      ST_SETUP: begin
        if (t_zero) begin
          st_d   = ST_HIGH;
          t_load = 1'b1;
          t_val  = LD_HIGH;
        end
      end
      ST_HIGH: begin
        if (t_zero) begin
          sh_shift = 1'b1;
          t_load   = 1'b1;
          if (last_bit) begin
            st_d  = ST_HOLD;
            t_val = LD_HOLD;
          end else begin
            st_d  = ST_LOW;
            t_val = LD_LOW;
          end
        end
      end
      ST_LOW: begin
        if (t_zero) begin
          st_d   = ST_HIGH;
          t_load = 1'b1;
          t_val  = LD_HIGH;
        end
      end
      ST_HOLD: begin
        if (t_zero) begin
          st_d   = ST_SETTLE;
          t_load = 1'b1;
          t_val  = LD_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (t_zero) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign en_n_d = (st_d == ST_IDLE) || (st_d == ST_SETTLE);
  assign sclk_d = (st_d == ST_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      en_n_q <= 1'b1;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      en_n_q <= en_n_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
    end
  end

  assign en_n = en_n_q;
  assign sclk = sclk_q;
  assign done = done_q;
  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/gsm_amp.sv
module gsm_amp #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  input  logic busy,
  output logic amp_en
);
  logic en_q, pend_v_q, pend_d_q;
  logic wr_now, wr_park, apply_pend;

  assign wr_now     = wr & ~busy;
  assign wr_park    = wr & busy;
  assign apply_pend = pend_v_q & ~busy & ~wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= RST_VAL;
    end else if (wr_now) begin
      en_q <= wdata;
    end else if (apply_pend) begin
      en_q <= pend_d_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_d_q <= 1'b0;
    end else if (wr_park) begin
      pend_v_q <= 1'b1;
      pend_d_q <= wdata;
    end else if (wr_now || apply_pend) begin
      pend_v_q <= 1'b0;
    end
  end

  assign amp_en = en_q;
endmodule

// File: rtl/gain_serial_master.sv
module gain_serial_master #(
  parameter int   CODE_W        = 8,
  parameter int   EN_SETUP_CYC  = 3,
  parameter int   CLK_HIGH_CYC  = 2,
  parameter int   CLK_LOW_CYC   = 2,
  parameter int   EN_HOLD_CYC   = 1,
  parameter int   SETTLE_CYC    = 4,
  parameter logic AMP_EN_RST    = 1'b0,
  parameter int   SYS_PERIOD_PS = 8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  output logic              req_ready,
  input  logic              amp_wr,
  input  logic              amp_wdata,
  output logic              amp_en,
  output logic              ser_en_n,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              busy,
  output logic              done
);
  localparam int MAX_CYC = gsm_pkg::max2(gsm_pkg::max2(EN_SETUP_CYC, SETTLE_CYC),
                           gsm_pkg::max2(gsm_pkg::max2(CLK_HIGH_CYC, CLK_LOW_CYC), EN_HOLD_CYC));
  localparam int TW = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  // reset is asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic          fire, t_load, t_zero, sh_load, sh_shift, last_bit;
  logic [TW-1:0] t_val;

  assign req_ready = ~busy;
  assign fire      = req_valid & req_ready;

  gsm_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  gsm_shift #(.CODE_W(CODE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .load      (sh_load),
    .load_code (req_code),
    .shift     (sh_shift),
    .dout      (ser_dat),
    .last_bit  (last_bit)
  );

  gsm_seq #(
    .TW           (TW),
    .EN_SETUP_CYC (EN_SETUP_CYC),
    .CLK_HIGH_CYC (CLK_HIGH_CYC),
    .CLK_LOW_CYC  (CLK_LOW_CYC),
    .EN_HOLD_CYC  (EN_HOLD_CYC),
    .SETTLE_CYC   (SETTLE_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .fire     (fire),
    .t_zero   (t_zero),
    .last_bit (last_bit),
    .t_load   (t_load),
    .t_val    (t_val),
    .sh_load  (sh_load),
    .sh_shift (sh_shift),
    .en_n     (ser_en_n),
    .sclk     (ser_clk),
    .done     (done),
    .busy     (busy)
  );

  gsm_amp #(.RST_VAL(AMP_EN_RST)) u_amp (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .wr     (amp_wr),
    .wdata  (amp_wdata),
    .busy   (busy),
    .amp_en (amp_en)
  );
endmodule

// File: rtl/gsm_checker.sv
module gsm_checker #(
  parameter int SYS_PERIOD_PS = 8000
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic ser_en_n,
  input logic ser_clk,
  input logic ser_dat,
  input logic amp_en
);
  localparam longint P         = longint'(SYS_PERIOD_PS);
  localparam longint HIGH_PS   = 12000;
  localparam longint PERIOD_PS = 32000;
  localparam longint DSU_PS    = 6500;
  localparam longint DHO_PS    = 5000;
  localparam longint ESU_PS    = 17000;
  localparam longint EHO_PS    = 3000;
  localparam longint SETL_PS   = 30000;

  logic        p_clk, p_en, p_dat, seen_rise;
  logic [15:0] hi_run, en_lo_run, dat_run, rr_run, en_hi_run;
  logic        rise;

  assign rise = ser_clk & ~p_clk;

  function automatic logic [15:0] inc(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_clk     <= 1'b0;
      p_en      <= 1'b1;
      p_dat     <= 1'b0;
      seen_rise <= 1'b0;
      hi_run    <= '0;
      en_lo_run <= '0;
      dat_run   <= '0;
      rr_run    <= '0;
      en_hi_run <= '0;
    end else begin
      p_clk     <= ser_clk;
      p_en      <= ser_en_n;
      p_dat     <= ser_dat;
      if (ser_clk)   hi_run    <= p_clk ? inc(hi_run) : 16'd1;
      if (!ser_en_n) en_lo_run <= p_en ? 16'd1 : inc(en_lo_run);
      if (ser_en_n)  en_hi_run <= p_en ? inc(en_hi_run) : 16'd1;
      dat_run   <= (ser_dat != p_dat) ? 16'd1 : inc(dat_run);
      rr_run    <= rise ? 16'd1 : inc(rr_run);
      seen_rise <= ser_en_n ? 1'b0 : (rise ? 1'b1 : seen_rise);
    end
  end

  assert_clk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !ser_en_n);

  assert_dat_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && ser_en_n));

  assert_no_ready_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_amp_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(amp_en));

  assert_clk_high_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (longint'(hi_run) * P >= HIGH_PS) && (longint'(hi_run) * P >= DHO_PS));

  assert_clk_period_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && seen_rise) |-> (longint'(rr_run) * P >= PERIOD_PS));

  assert_dat_setup_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (longint'(dat_run) * P >= DSU_PS));

  assert_en_setup_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (longint'(en_lo_run) * P >= ESU_PS));

  assert_en_hold_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_en_n) |-> (longint'(rr_run) * P >= EHO_PS));

  assert_settle_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (longint'(en_hi_run) * P >= SETL_PS));
endmodule

bind gain_serial_master gsm_checker #(.SYS_PERIOD_PS(SYS_PERIOD_PS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .ser_en_n  (ser_en_n),
  .ser_clk   (ser_clk),
  .ser_dat   (ser_dat),
  .amp_en    (amp_en)
);

// File: tb/sim_gain_serial_master.sv
module sim_gain_serial_master;
  localparam int W      = 8;
  localparam int SU     = 3;
  localparam int HI     = 2;
  localparam int LO     = 2;
  localparam int HO     = 1;
  localparam int ST     = 4;
  localparam int PER_PS = 8000;

  logic         clk, rst_n;
  logic         req_valid, req_ready;
  logic [W-1:0] req_code;
  logic         amp_wr, amp_wdata, amp_en;
  logic         ser_en_n, ser_clk, ser_dat, busy, done;

  gain_serial_master #(
    .CODE_W(W), .EN_SETUP_CYC(SU), .CLK_HIGH_CYC(HI), .CLK_LOW_CYC(LO),
    .EN_HOLD_CYC(HO), .SETTLE_CYC(ST), .AMP_EN_RST(1'b0), .SYS_PERIOD_PS(PER_PS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_ready(req_ready), .amp_wr(amp_wr), .amp_wdata(amp_wdata), .amp_en(amp_en),
    .ser_en_n(ser_en_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit meets_ps(input int cycles, input int min_ps);
    return cycles * PER_PS >= min_ps;
  endfunction

  logic [W-1:0] expq[$];

  // pin monitor
  bit           mon_on = 0;
  logic         p_en, p_clk, p_dat;
  int           run, pulses, sc;
  bit           wait_done;
  logic [W-1:0] word;
  int           frames = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (ser_en_n && ser_clk) chk(0, "R3 clock outside burst", 1, 0);
      if (busy && req_ready)   chk(0, "R8 ready while busy", 1, 0);
      if (ser_clk && p_clk && ser_dat != p_dat) chk(0, "R6 data moved while high", ser_dat, p_dat);
      if (!ser_en_n && p_en) begin
        pulses = 0;
        word   = '0;
      end
      if (ser_clk && !p_clk) begin
        if (pulses == 0) begin
          chk(run == SU, "R5 enable lead", run, SU);
          chk(meets_ps(run, 17000), "R10 enable setup", run * PER_PS, 17000);
        end else begin
          chk(run == LO, "R5 low phase", run, LO);
          chk(meets_ps(run, 6500) && meets_ps(run + HI, 32000), "R10 data setup/period", run * PER_PS, 6500);
        end
        word   = {word[W-2:0], ser_dat};
        pulses = pulses + 1;
      end
      if (!ser_clk && p_clk) begin
        chk(run == HI, "R5 high phase", run, HI);
        chk(meets_ps(run, 12000), "R10 clock high", run * PER_PS, 12000);
      end
      if (ser_en_n && !p_en) begin
        logic [W-1:0] e;
        chk(pulses == W, "R3 pulse count", pulses, W);
        chk(run == HO, "R5 enable hold", run, HO);
        chk(meets_ps(run + HI, 3000), "R10 enable hold", (run + HI) * PER_PS, 3000);
        if (expq.size() == 0) begin
          chk(0, "R4 frame with no request", word, 0);
        end else begin
          e = expq.pop_front();
          chk(word == e, "R4 word MSB first", word, e);
        end
        wait_done = 1;
        sc = 0;
      end else if (wait_done) begin
        sc = sc + 1;
        if (done) begin
          chk(sc == ST, "R7 settle delay", sc, ST);
          chk(meets_ps(sc, 30000), "R10 settle", sc * PER_PS, 30000);
          chk(!busy, "R7 busy cleared with done", busy, 0);
          wait_done = 0;
          frames++;
        end else if (sc > ST) begin
          chk(0, "R7 done missing", sc, ST);
          wait_done = 0;
        end
      end else if (done) begin
        chk(0, "R7 stray done", 1, 0);
      end
      if (ser_clk != p_clk || ser_en_n != p_en) run = 1;
      else run = run + 1;
      p_en  = ser_en_n;
      p_clk = ser_clk;
      p_dat = ser_dat;
    end
  end

  task automatic send(input logic [W-1:0] code, input bit expect_wait);
    @(negedge clk);
    req_valid = 1'b1;
    req_code  = code;
    if (expect_wait) chk(!req_ready, "R8 request held during frame", req_ready, 0);
    while (!req_ready) @(negedge clk);
    expq.push_back(code);
    @(negedge clk);
    req_valid = 1'b0;
    req_code  = $urandom;
    chk(!ser_en_n && busy, "R2 frame starts after accept", {ser_en_n, busy}, 1);
  endtask

  task automatic amp_write(input logic v);
    @(negedge clk);
    amp_wr    = 1'b1;
    amp_wdata = v;
    @(negedge clk);
    amp_wr    = 1'b0;
    amp_wdata = $urandom;
  endtask

  task automatic wait_done_pin();
    while (!done) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      chk(0, "watchdog expired", cyc, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_code = '0; amp_wr = 1'b0; amp_wdata = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ser_en_n == 1 && ser_clk == 0 && ser_dat == 0, "R1 serial pins in reset",
        {ser_en_n, ser_clk, ser_dat}, 3'b100);
    chk(!busy && req_ready && !done && amp_en == 0, "R1 status in reset",
        {busy, req_ready, done, amp_en}, 4'b0100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ser_en_n == 1 && ser_clk == 0 && !busy && amp_en == 0, "R1 state after release",
        {ser_en_n, ser_clk, busy, amp_en}, 4'b1000);
    p_en = ser_en_n; p_clk = ser_clk; p_dat = ser_dat; run = 1; wait_done = 0;
    mon_on = 1;

    // directed corner codes
    send(8'h00, 0); wait_done_pin();
    send(8'hFF, 0); wait_done_pin();
    send(8'h80, 0); wait_done_pin();
    send(8'h01, 0); wait_done_pin();
    send(8'hA5, 0);
    // R8 back-to-back: second request waits for the frame to end
    send(8'h5A, 1);
    wait_done_pin();

    // R9 idle write takes effect next cycle
    amp_write(1'b1);
    chk(amp_en == 1, "R9 idle write", amp_en, 1);
    // R9 writes during a frame are parked, last one wins
    send(8'h3C, 0);
    amp_write(1'b0);
    chk(amp_en == 1, "R9 held during frame", amp_en, 1);
    amp_write(1'b1);
    amp_write(1'b0);
    chk(amp_en == 1, "R9 still held", amp_en, 1);
    wait_done_pin();
    chk(amp_en == 1, "R9 unchanged at done", amp_en, 1);
    @(negedge clk);
    chk(amp_en == 0, "R9 parked value applied", amp_en, 0);

    // constrained random frames with random gaps
    for (int i = 0; i < 40; i++) begin
      int gap;
      gap = $urandom % 4;
      send(W'($urandom), 0);
      if (gap != 0) begin
        wait_done_pin();
        repeat (gap) @(negedge clk);
      end
    end
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R4 every request sent", expq.size(), 0);
    chk(frames == 47, "R3 frame count", frames, 47);
    finished = 1;
    summary();
    $finish;
  end
endmodule